// File: doc/BRIEF.md
# Trigger Event Conditioning Unit

This block turns a set of asynchronous trigger lines into clean, single-cycle event strobes for a timer/counter. It serves five event channels: reload, start, stop, count and capture. Each channel chooses its own source from the trigger lines or from one of two constant sources (logic 0 and logic 1). It detects a rising edge, a falling edge or either edge on that source, or passes the level through. The result is merged with a software command pulse for the same channel.

All trigger lines pass through one shared synchronizer clocked by the fast system clock. Detected events are then held in a one-deep pending flag until the next counter-clock tick. A tick is a one-cycle enable that marks the slower counter clock. The strobe leaves the block in the cycle after that tick. Several events that arrive between two ticks merge into one strobe. Nothing is queued. Configuration arrives on plain input ports.

Top module: `trig_event_cond`

## Requirements
- R1: While reset is held, and in the first cycle after it, every event output is 0.
- R2: Each channel has a select field. Code 0 selects constant 0. Code 1 selects constant 1. Code k+2 selects trigger line k. Any code above the last trigger line behaves as constant 0.
- R3: A trigger line passes through two synchronizer flops. A change driven before clock edge t is seen by edge detection at edge t+2. Given a tick at that edge, the resulting strobe is high in the cycle after edge t+2.
- R4: Mode 2'b00 (rising) fires when the synchronized source is 1 and was 0 one cycle earlier.
- R5: Mode 2'b01 (falling) fires when the synchronized source is 0 and was 1 one cycle earlier.
- R6: Mode 2'b10 (both) fires when the synchronized source differs from its value one cycle earlier.
- R7: Mode 2'b11 (level) fires in every cycle in which the synchronized source is 1.
- R8: A constant source (select codes 0, 1 and out-of-range codes) never fires in the three edge modes. In level mode, constant 1 fires on every tick.
- R9: A software command bit high before clock edge t fires its channel's event at that edge, whatever the hardware trigger, mode or select.
- R10: The strobe of a channel goes high only in the cycle after a clock edge at which the tick input is high. It then reports whether an event was detected at that edge or since the previous tick. Events that arrive between ticks merge into a single strobe.
- R11: Each of the five channels uses its own select, mode and command bit. Channel order is: 0 reload, 1 start, 2 stop, 3 count, 4 capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | NUM_TRIG | Asynchronous trigger lines |
| chan_sel | input | 5*SEL_W | Per-channel source select; channel e in bits [e*SEL_W +: SEL_W] |
| chan_mode | input | 10 | Per-channel 2-bit detection mode; channel e in bits [2e+1:2e] |
| sw_cmd | input | 5 | Per-channel software command pulse |
| cnt_tick | input | 1 | One-cycle enable marking a counter-clock period |
| evt_out | output | 5 | Per-channel event strobe |

## Verification
The bench builds the block with NUM_TRIG = 3, which gives a 3-bit select. That size brings every select code into reach: both constants, all three lines, and three out-of-range codes. The bench sweeps 32 configurations. Across them every channel meets every pairing of select code and mode. Each configuration runs a pseudo-random stream of trigger values and occasional software commands. One pass has a tick on every cycle. A second pass has sparse ticks, which exercises the merging of events between ticks. A small arithmetic reference in the bench predicts every strobe from the values driven two and three cycles earlier.

// File: rtl/trig_evt_pkg.sv
// Shared types and constants for the trigger event conditioning unit.
// Assumes five event channels and two constant sources ahead of the pins.
package trig_evt_pkg;

    // Detection mode encoding per channel
    typedef enum logic [1:0] {
        EM_RISE  = 2'b00,
        EM_FALL  = 2'b01,
        EM_BOTH  = 2'b10,
        EM_LEVEL = 2'b11
    } evt_mode_e;

    localparam int NUM_EVT    = 5;
    localparam int CONST_SRCS = 2;
    localparam int MODE_W     = 2;

    // Channel indices
    localparam int EV_RELOAD  = 0;
    localparam int EV_START   = 1;
    localparam int EV_STOP    = 2;
    localparam int EV_COUNT   = 3;
    localparam int EV_CAPTURE = 4;

    // Select width needed for n trigger pins plus the constant sources
    function automatic int sel_width(input int n);
        return $clog2(n + CONST_SRCS);
    endfunction

endpackage

// File: rtl/trig_sync_bank.sv
// Shared synchronizer for all trigger lines.
// Each line passes through SYNC_DEPTH flops clocked by the fast clock.
// Assumes the lines are asynchronous and need no glitch filtering.
module trig_sync_bank #(
    parameter int NUM_TRIG   = 12,
    parameter int SYNC_DEPTH = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TRIG-1:0] trig_in,
    output logic [NUM_TRIG-1:0] trig_sync
);

    logic [NUM_TRIG-1:0] stage_q [SYNC_DEPTH];

    generate
        for (genvar d = 0; d < SYNC_DEPTH; d++) begin : g_stage
            if (d == 0) begin : g_first
                // First stage: capture the raw asynchronous lines
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= trig_in;
                end
            end else begin : g_next
                // Later stages: shift the previous stage forward
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[d] <= '0;
                    else        stage_q[d] <= stage_q[d-1];
                end
            end
        end
    endgenerate

    assign trig_sync = stage_q[SYNC_DEPTH-1];

    generate
        if (SYNC_DEPTH == 2) begin : g_lat_chk
            logic [1:0] warm_q;
            // Count cycles since reset so that the latency check sees valid history
            always_ff @(posedge clk) begin
                if (!rst_n)            warm_q <= '0;
                else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
            end
            // R3
            sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (warm_q == 2'd2) |-> (trig_sync == $past(trig_in, 2)));
        end
    endgenerate

endmodule

// File: rtl/trig_edge_det.sv
// Edge/level detector for one channel.
// It keeps a one-flop history of the selected synchronized source.
// It masks edges on constant sources and merges in the software command.
// Assumes src_i is already synchronous to clk.
module trig_edge_det
    import trig_evt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      src_i,
    input  logic      src_const_i,
    input  evt_mode_e mode_i,
    input  logic      sw_i,
    output logic      det_o
);

    logic hist_q;
    logic hw_det;
    logic edge_mode;

    // Remember the previous source value for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= 1'b0;
        else        hist_q <= src_i;
    end

    // Decode the configured detection condition
    always_comb begin
        unique case (mode_i)
            EM_RISE:  hw_det = src_i & ~hist_q;
            EM_FALL:  hw_det = ~src_i & hist_q;
            EM_BOTH:  hw_det = src_i ^ hist_q;
            default:  hw_det = src_i;
        endcase
    end

    assign edge_mode = (mode_i != EM_LEVEL);
    assign det_o     = (hw_det & ~(src_const_i & edge_mode)) | sw_i;

    // R4
    rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode_i == EM_RISE && det_o && !sw_i) |-> (src_i && !$past(src_i)));

    // R5
    fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode_i == EM_FALL && det_o && !sw_i) |-> (!src_i && $past(src_i)));

    // R8
    const_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_const_i && edge_mode && !sw_i) |-> !det_o);

    // R9
    sw_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_i |-> det_o);

endmodule

// File: rtl/trig_tick_gate.sv
// Holds one detected event until the next counter-clock tick, then emits
// a one-cycle strobe. Extra events before the tick merge into one.
// Assumes cnt_tick_i is a one-cycle enable synchronous to clk.
module trig_tick_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic det_i,
    input  logic cnt_tick_i,
    output logic evt_o
);

    logic pend_q;
    logic req;

    assign req = pend_q | det_i;

    // Keep an unreported event until a tick consumes it
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (cnt_tick_i) pend_q <= 1'b0;
        else                 pend_q <= req;
    end

    // Emit the strobe in the cycle after a tick
    always_ff @(posedge clk) begin
        if (!rst_n) evt_o <= 1'b0;
        else        evt_o <= cnt_tick_i & req;
    end

    // R10
    no_idle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cnt_tick_i) |-> !evt_o);

    // R10
    tick_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cnt_tick_i) && $past(det_i)) |-> evt_o);

    // R10
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_tick_i |=> (!pend_q || $past(!cnt_tick_i)));

endmodule

// File: rtl/trig_event_cond.sv
// Top of the trigger event conditioning unit.
// Synchronizes all trigger lines once. Then, for each of five channels, it
// selects a source, detects the configured edge or level, merges in the
// software command and hands the result to the tick gate.
// Assumes the configuration is held stable while events are expected.
module trig_event_cond
    import trig_evt_pkg::*;
#(
    parameter int  NUM_TRIG   = 12,
    parameter int  SYNC_DEPTH = 2,
    localparam int SEL_W      = sel_width(NUM_TRIG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_TRIG-1:0]       trig_in,
    input  logic [NUM_EVT*SEL_W-1:0]  chan_sel,
    input  logic [NUM_EVT*MODE_W-1:0] chan_mode,
    input  logic [NUM_EVT-1:0]        sw_cmd,
    input  logic                      cnt_tick,
    output logic [NUM_EVT-1:0]        evt_out
);

    localparam int PIN_BASE = CONST_SRCS;
    localparam int PIN_LAST = CONST_SRCS + NUM_TRIG - 1;

    logic [NUM_TRIG-1:0] trig_sync;

    trig_sync_bank #(
        .NUM_TRIG   (NUM_TRIG),
        .SYNC_DEPTH (SYNC_DEPTH)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_in   (trig_in),
        .trig_sync (trig_sync)
    );

    generate
        for (genvar e = 0; e < NUM_EVT; e++) begin : g_chan
            logic [SEL_W-1:0] sel;
            logic             src_val;
            logic             src_const;
            logic             det;
            evt_mode_e        mode;

            assign sel  = chan_sel[e*SEL_W +: SEL_W];
            assign mode = evt_mode_e'(chan_mode[e*MODE_W +: MODE_W]);

            // Pick the channel source: constant or synchronized pin
            always_comb begin
                src_val   = (sel == SEL_W'(1));
                src_const = 1'b1;
                for (int k = 0; k < NUM_TRIG; k++) begin
                    if (int'(sel) == k + PIN_BASE) begin
                        src_val   = trig_sync[k];
                        src_const = 1'b0;
                    end
                end
            end

            trig_edge_det u_det (
                .clk         (clk),
                .rst_n       (rst_n),
                .src_i       (src_val),
                .src_const_i (src_const),
                .mode_i      (mode),
                .sw_i        (sw_cmd[e]),
                .det_o       (det)
            );

            trig_tick_gate u_gate (
                .clk        (clk),
                .rst_n      (rst_n),
                .det_i      (det),
                .cnt_tick_i (cnt_tick),
                .evt_o      (evt_out[e])
            );

            // R2
            sel_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (int'(sel) > PIN_LAST || sel == '0) |-> !src_val);
        end
    endgenerate

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !$past(rst_n) |-> (evt_out == '0));

endmodule

// File: tb/trig_event_cond_tb.sv
// Sweep bench: 3 trigger lines, 3-bit selects, every select/mode pairing on
// every channel, with dense and then sparse ticks.
module trig_event_cond_tb;

    localparam int NT    = 3;
    localparam int SW    = 3;
    localparam int NE    = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NT-1:0]   trig_in = '0;
    logic [NE*SW-1:0] chan_sel = '0;
    logic [NE*2-1:0] chan_mode = '0;
    logic [NE-1:0]   sw_cmd = '0;
    logic            cnt_tick = 1'b0;
    logic [NE-1:0]   evt_out;

    int tests = 0;
    int fails = 0;

    logic [NT-1:0] hist [4];
    logic [NE-1:0] pend_m = '0;
    logic [15:0]   lfsr = 16'hACE1;

    always #10 clk = ~clk;

    trig_event_cond #(.NUM_TRIG(NT)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_in   (trig_in),
        .chan_sel  (chan_sel),
        .chan_mode (chan_mode),
        .sw_cmd    (sw_cmd),
        .cnt_tick  (cnt_tick),
        .evt_out   (evt_out)
    );

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // R2: source value from a driven trigger vector for a select code
    function automatic logic srcv(input int sel, input logic [NT-1:0] v);
        if (sel == 1) return 1'b1;
        if (sel >= 2 && sel < NT + 2) return v[sel-2];
        return 1'b0;
    endfunction

    function automatic int sel_of(input int e);
        return int'(chan_sel[e*SW +: SW]);
    endfunction

    function automatic int mode_of(input int e);
        return int'(chan_mode[e*2 +: 2]);
    endfunction

    task automatic next_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // One cycle: drive at negedge, predict, take the edge, compare
    task automatic step(input logic [NT-1:0] tr, input logic [NE-1:0] sw,
                        input logic tick, input bit chk, input int cfg);
        logic [NE-1:0] exp;
        string tag;
        trig_in  = tr;
        sw_cmd   = sw;
        cnt_tick = tick;
        hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = tr;
        for (int e = 0; e < NE; e++) begin
            // R3: detection sees the value driven two and three edges back
            logic s, h, d;
            int sl, md;
            sl = sel_of(e);
            md = mode_of(e);
            s = srcv(sl, hist[2]);
            h = srcv(sl, hist[3]);
            case (md)
                0: d = s & ~h;
                1: d = ~s & h;
                2: d = s ^ h;
                default: d = s;
            endcase
            if (!(sl >= 2 && sl < NT + 2) && md != 3) d = 1'b0;
            d = d | sw[e];
            exp[e] = tick & (pend_m[e] | d);
            pend_m[e] = tick ? 1'b0 : (pend_m[e] | d);
        end
        @(posedge clk);
        @(negedge clk);
        if (chk) begin
            for (int e = 0; e < NE; e++) begin
                // R11: each channel judged against its own configuration
                if (sw[e])                tag = "R9";
                else if (!tick)           tag = "R10";
                else if (!(sel_of(e) >= 2 && sel_of(e) < NT + 2) && mode_of(e) != 3) tag = "R8";
                else if (mode_of(e) == 0) tag = "R4";
                else if (mode_of(e) == 1) tag = "R5";
                else if (mode_of(e) == 2) tag = "R6";
                else                      tag = "R7";
                tests++;
                if (evt_out[e] !== exp[e]) begin
                    fails++;
                    $display("FAIL %s ch%0d cfg%0d sel%0d mode%0d: evt_out=%0b expected %0b",
                             tag, e, cfg, sel_of(e), mode_of(e), evt_out[e], exp[e]);
                end
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) hist[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs quiet during reset
        tests++;
        if (evt_out !== '0) begin
            fails++;
            $display("FAIL R1 in reset: evt_out=%b expected 00000", evt_out);
        end
        rst_n = 1'b1;
        cnt_tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R1: first cycle after reset
        tests++;
        if (evt_out !== '0) begin
            fails++;
            $display("FAIL R1 after reset: evt_out=%b expected 00000", evt_out);
        end
        for (int pass = 0; pass < 2; pass++) begin
            for (int c = 0; c < 32; c++) begin
                // R2 R11: spread select codes and modes over the channels
                for (int e = 0; e < NE; e++) begin
                    chan_sel[e*SW +: SW] = SW'((c + 3 * e) % 8);
                    chan_mode[e*2 +: 2]  = 2'((c / 8 + e) % 4);
                end
                // Settle on zeros; the first step may see the old source in history
                step('0, '0, 1'b1, 1'b0, c);
                step('0, '0, 1'b1, 1'b1, c);
                step('0, '0, 1'b1, 1'b1, c);
                for (int t = 0; t < 12; t++) begin
                    logic [NE-1:0] sw;
                    logic tk;
                    next_lfsr();
                    sw = (lfsr[15:13] == 3'b000) ? lfsr[9:5] : '0;
                    tk = (pass == 0) ? 1'b1 : (lfsr[12:11] == 2'b00);
                    step(lfsr[2:0], sw, tk, 1'b1, c);
                end
            end
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule